// File: doc/BRIEF.md
# Dual Address Generator for a 16-bit Signal-Processing Core

This block forms data-memory addresses for a 16-bit core whose data space is byte addressed over 64 KB. It contains two generators that run side by side. The primary generator (X) serves every instruction. It computes the effective address and the updated pointer for direct, pre- and post-modify, register-plus-offset and bit-reversed addressing. Circular buffers can be formed with modulo bounds. X drives both a read strobe and a write strobe.

The secondary generator (Y) is used only while a multiply-accumulate operation fetches its second operand. This allows two operand reads in the same cycle. Y is tied to the two pointer registers with indices 6 and 7. It supports only post-modify updates, with optional modulo wrapping, and always fetches whole words. Y has a read strobe and no write strobe.

An accumulator store always travels on the X bus as a word write to whatever address X computes. The instruction decoder supplies the controls, the register file supplies the pointers and receives the updated value, and the memory arrays consume the addresses. All outputs are registered and appear on the clock edge after the request.

Top module: `agu_dual`

## Requirements
- R1: While synchronous active-low reset is held, on the next clock edge all strobes go low and every address, updated pointer and index output is zero.
- R2: An X request is reflected one edge later. The mode codes are: 0 direct (EA=ptr, pointer kept), 1 post-increment, 2 post-decrement, 3 pre-increment (EA and pointer both ptr+step), 4 pre-decrement, and 5 offset (EA=ptr+offset, pointer kept). The step is 1 for a byte access and 2 for a word access.
- R3: A word X access clears bit 0 of the emitted EA; a byte access keeps it.
- R4: With modulo enabled, a modified pointer value v above the upper bound hi becomes lo+(v-hi-1), and a value below lo becomes hi-(lo-v-1). This holds for X modes 1 to 4 and for every Y update.
- R5: Mode 6 (bit-reversed) gives EA=ptr. The pointer is updated by adding one at the top bit of an N-bit field, with the carry running toward lower bits and the carry out dropped. N is the value of x_brev_n. The field starts at bit 1 for a word access and at bit 0 for a byte access. The other bits are kept.
- R6: An accumulator store produces an X write (x_wr high, x_rd low) of word size, even when x_byte is high.
- R7: Y emits only a read strobe. Its EA is always even, and it fetches a whole word from the selected pointer.
- R8: Y uses pointer 6 when y_sel is 0 and pointer 7 when y_sel is 1, and reports that index on y_ptr_idx.
- R9: Y post-modify codes are: 0 no change, 1 +2, 2 -2, 3 +4. The EA is always the pointer before the update.
- R10: When mac_en is low, y_rd goes low and y_ea and y_ptr_upd keep their previous values.
- R11: When x_req is low, both X strobes go low and x_ea and x_ptr_upd keep their previous values.
- R12: x_rd and x_wr are never high together, and an X request asserts exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_req | input | 1 | X access request this cycle |
| x_write | input | 1 | X access is a write |
| acc_store | input | 1 | Accumulator store: forced word write on X |
| x_mode | input | 3 | X addressing mode code |
| x_byte | input | 1 | X access is byte sized |
| x_ptr | input | 16 | X pointer register value |
| x_offset | input | 16 | Offset for mode 5 |
| x_mod_en | input | 1 | X modulo enable |
| x_mod_lo | input | 16 | X circular buffer first address |
| x_mod_hi | input | 16 | X circular buffer last address |
| x_brev_n | input | 4 | Bit-reversed field width |
| mac_en | input | 1 | Multiply-accumulate operand fetch active |
| y_sel | input | 1 | Selects pointer 7 (1) or 6 (0) |
| y_ptr6 | input | 16 | Value of pointer register 6 |
| y_ptr7 | input | 16 | Value of pointer register 7 |
| y_op | input | 2 | Y post-modify code |
| y_mod_en | input | 1 | Y modulo enable |
| y_mod_lo | input | 16 | Y circular buffer first address |
| y_mod_hi | input | 16 | Y circular buffer last address |
| x_ea | output | 16 | X effective address |
| x_ptr_upd | output | 16 | Updated X pointer value |
| x_rd | output | 1 | X read strobe |
| x_wr | output | 1 | X write strobe |
| y_ea | output | 16 | Y effective address |
| y_ptr_upd | output | 16 | Updated Y pointer value |
| y_ptr_idx | output | 4 | Index of the Y pointer being updated |
| y_rd | output | 1 | Y read strobe |

## Verification
On every cycle, the assertions check that the X strobes are mutually exclusive and that an accumulator store becomes a write. They also check that word X addresses and all Y addresses are even, that Y reports only index 6 or 7, and that both generators hold their outputs when idle. A further assertion checks that an in-range post-incremented pointer stays inside its modulo buffer. The actual address arithmetic needs the bench's sweeps, which compare against values computed independently from the rules above. This covers every X mode for both sizes across a pointer range that straddles the modulo bounds, the reversed-carry sequence, and every Y code on both pointers with and without wrapping.

// File: rtl/agu_pkg.sv
// Shared types for the dual address generator.
// Assumes: mode codes are fixed by the instruction decoder that drives them.
package agu_pkg;

    // X addressing modes (code values are decoded by the instruction decoder)
    typedef enum logic [2:0] {
        XM_DIRECT  = 3'd0,
        XM_POSTINC = 3'd1,
        XM_POSTDEC = 3'd2,
        XM_PREINC  = 3'd3,
        XM_PREDEC  = 3'd4,
        XM_OFFSET  = 3'd5,
        XM_BITREV  = 3'd6,
        XM_RSVD    = 3'd7
    } xmode_e;

    // Y post-modify codes
    typedef enum logic [1:0] {
        YOP_HOLD  = 2'd0,
        YOP_INC2  = 2'd1,
        YOP_DEC2  = 2'd2,
        YOP_INC4  = 2'd3
    } yop_e;

endpackage

// File: rtl/agu_modwrap.sv
// Circular-buffer wrap of a modified pointer value.
// Assumes lo <= hi and that a single step never overshoots by more than the
// buffer length; values inside [lo,hi] or with wrapping disabled pass through.
module agu_modwrap #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] val,
    input  logic          en,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] res
);
    // Fold an overshoot past either bound back into the buffer
    always_comb begin
        if (en && (val > hi))
            res = lo + (val - hi - AW'(1));
        else if (en && (val < lo))
            res = hi - (lo - val - AW'(1));
        else
            res = val;
    end
endmodule

// File: rtl/agu_bitrev.sv
// Reversed-carry increment of an N-bit field inside a pointer.
// The field starts at bit 1 for word accesses and bit 0 for byte accesses;
// one is added at the field's top bit and the carry runs downward, carry out
// dropped. N = 0 leaves the pointer unchanged. Assumes N + start <= AW.
module agu_bitrev #(
    parameter int AW = 16,
    parameter int BW = 4
) (
    input  logic [AW-1:0] val,
    input  logic          word_op,
    input  logic [BW-1:0] nbits,
    output logic [AW-1:0] res
);
    // Mirror the low n bits of v; bits at and above n come out zero
    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v, input int n);
        logic [AW-1:0] r;
        r = '0;
        for (int i = 0; i < AW; i++) begin
            for (int j = 0; j < AW; j++) begin
                if ((i < n) && (j == n - 1 - i))
                    r[i] = v[j];
            end
        end
        return r;
    endfunction

    logic [AW-1:0] mask;
    logic [AW-1:0] field;
    logic [AW-1:0] next_field;
    int            shamt;

    // Extract the field, add one in mirrored order, and merge it back
    always_comb begin
        shamt      = word_op ? 1 : 0;
        mask       = (AW'(1) << nbits) - AW'(1);
        field      = (val >> shamt) & mask;
        next_field = mirror(mirror(field, int'(nbits)) + AW'(1), int'(nbits)) & mask;
        res        = (val & ~(mask << shamt)) | (next_field << shamt);
    end
endmodule

// File: rtl/agu_x_gen.sv
// Primary address generator: all addressing modes for one access.
// Purely combinational; the top registers its results. Assumes the offset is
// already sign-extended to AW bits by the decoder. An accumulator store is
// always word sized regardless of the byte flag.
module agu_x_gen
    import agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 4
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] offset,
    input  xmode_e        mode,
    input  logic          byte_op,
    input  logic          acc_store,
    input  logic          mod_en,
    input  logic [AW-1:0] mod_lo,
    input  logic [AW-1:0] mod_hi,
    input  logic [BW-1:0] brev_n,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] ptr_upd
);
    logic          word_op;
    logic [AW-1:0] step;
    logic [AW-1:0] inc_raw;
    logic [AW-1:0] dec_raw;
    logic [AW-1:0] inc_wrap;
    logic [AW-1:0] dec_wrap;
    logic [AW-1:0] brev_next;
    logic [AW-1:0] ea_raw;

    // Access size and the scaled pointer step
    always_comb begin
        word_op = !(byte_op && !acc_store);
        step    = word_op ? AW'(2) : AW'(1);
        inc_raw = ptr + step;
        dec_raw = ptr - step;
    end

    agu_modwrap #(.AW(AW)) u_wrap_inc (
        .val (inc_raw),
        .en  (mod_en),
        .lo  (mod_lo),
        .hi  (mod_hi),
        .res (inc_wrap)
    );

    agu_modwrap #(.AW(AW)) u_wrap_dec (
        .val (dec_raw),
        .en  (mod_en),
        .lo  (mod_lo),
        .hi  (mod_hi),
        .res (dec_wrap)
    );

    agu_bitrev #(.AW(AW), .BW(BW)) u_brev (
        .val     (ptr),
        .word_op (word_op),
        .nbits   (brev_n),
        .res     (brev_next)
    );

    // Select address and pointer update by mode
    always_comb begin
        ea_raw  = ptr;
        ptr_upd = ptr;
        unique case (mode)
            XM_POSTINC: ptr_upd = inc_wrap;
            XM_POSTDEC: ptr_upd = dec_wrap;
            XM_PREINC: begin
                ea_raw  = inc_wrap;
                ptr_upd = inc_wrap;
            end
            XM_PREDEC: begin
                ea_raw  = dec_wrap;
                ptr_upd = dec_wrap;
            end
            XM_OFFSET:  ea_raw  = ptr + offset;
            XM_BITREV:  ptr_upd = brev_next;
            default: begin
                ea_raw  = ptr;
                ptr_upd = ptr;
            end
        endcase
    end

    // Word accesses ignore the byte-select bit of the address
    always_comb begin
        ea = word_op ? {ea_raw[AW-1:1], 1'b0} : ea_raw;
    end
endmodule

// File: rtl/agu_y_gen.sv
// Secondary address generator for the second multiply-accumulate operand.
// Combinational; read-only and word-only, post-modify with optional modulo.
// Assumes the two dedicated pointer values arrive from the register file.
module agu_y_gen
    import agu_pkg::*;
#(
    parameter int AW        = 16,
    parameter int IW        = 4,
    parameter int PTR_A_IDX = 6,
    parameter int PTR_B_IDX = 7
) (
    input  logic [AW-1:0] ptr_a,
    input  logic [AW-1:0] ptr_b,
    input  logic          sel_b,
    input  yop_e          op,
    input  logic          mod_en,
    input  logic [AW-1:0] mod_lo,
    input  logic [AW-1:0] mod_hi,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] ptr_upd,
    output logic [IW-1:0] idx
);
    logic [AW-1:0] cur;
    logic [AW-1:0] moved;
    logic [AW-1:0] wrapped;

    // Pick the dedicated pointer and form the raw post-modified value
    always_comb begin
        cur = sel_b ? ptr_b : ptr_a;
        idx = sel_b ? IW'(PTR_B_IDX) : IW'(PTR_A_IDX);
        unique case (op)
            YOP_INC2: moved = cur + AW'(2);
            YOP_DEC2: moved = cur - AW'(2);
            YOP_INC4: moved = cur + AW'(4);
            default:  moved = cur;
        endcase
    end

    agu_modwrap #(.AW(AW)) u_wrap (
        .val (moved),
        .en  (mod_en && (op != YOP_HOLD)),
        .lo  (mod_lo),
        .hi  (mod_hi),
        .res (wrapped)
    );

    // Word-only fetch address and final pointer update
    always_comb begin
        ea      = {cur[AW-1:1], 1'b0};
        ptr_upd = wrapped;
    end
endmodule

// File: rtl/agu_dual.sv
// Top of the dual address generator: X and Y generators plus output registers.
// Every result is registered one edge after the request. Synchronous
// active-low reset clears all outputs. Assumes the decoder raises acc_store
// only together with x_req, and mac_en only for multiply-accumulate fetches.
module agu_dual
    import agu_pkg::*;
#(
    parameter int AW        = 16,
    parameter int RF_IDX_W  = 4,
    parameter int Y_PTR_A   = 6,
    parameter int Y_PTR_B   = 7,
    localparam int BW       = $clog2(AW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                x_req,
    input  logic                x_write,
    input  logic                acc_store,
    input  logic [2:0]          x_mode,
    input  logic                x_byte,
    input  logic [AW-1:0]       x_ptr,
    input  logic [AW-1:0]       x_offset,
    input  logic                x_mod_en,
    input  logic [AW-1:0]       x_mod_lo,
    input  logic [AW-1:0]       x_mod_hi,
    input  logic [BW-1:0]       x_brev_n,
    input  logic                mac_en,
    input  logic                y_sel,
    input  logic [AW-1:0]       y_ptr6,
    input  logic [AW-1:0]       y_ptr7,
    input  logic [1:0]          y_op,
    input  logic                y_mod_en,
    input  logic [AW-1:0]       y_mod_lo,
    input  logic [AW-1:0]       y_mod_hi,
    output logic [AW-1:0]       x_ea,
    output logic [AW-1:0]       x_ptr_upd,
    output logic                x_rd,
    output logic                x_wr,
    output logic [AW-1:0]       y_ea,
    output logic [AW-1:0]       y_ptr_upd,
    output logic [RF_IDX_W-1:0] y_ptr_idx,
    output logic                y_rd
);
    logic [AW-1:0]       xg_ea;
    logic [AW-1:0]       xg_upd;
    logic [AW-1:0]       yg_ea;
    logic [AW-1:0]       yg_upd;
    logic [RF_IDX_W-1:0] yg_idx;
    logic                x_is_write;

    agu_x_gen #(.AW(AW), .BW(BW)) u_xgen (
        .ptr       (x_ptr),
        .offset    (x_offset),
        .mode      (xmode_e'(x_mode)),
        .byte_op   (x_byte),
        .acc_store (acc_store),
        .mod_en    (x_mod_en),
        .mod_lo    (x_mod_lo),
        .mod_hi    (x_mod_hi),
        .brev_n    (x_brev_n),
        .ea        (xg_ea),
        .ptr_upd   (xg_upd)
    );

    agu_y_gen #(
        .AW        (AW),
        .IW        (RF_IDX_W),
        .PTR_A_IDX (Y_PTR_A),
        .PTR_B_IDX (Y_PTR_B)
    ) u_ygen (
        .ptr_a   (y_ptr6),
        .ptr_b   (y_ptr7),
        .sel_b   (y_sel),
        .op      (yop_e'(y_op)),
        .mod_en  (y_mod_en),
        .mod_lo  (y_mod_lo),
        .mod_hi  (y_mod_hi),
        .ea      (yg_ea),
        .ptr_upd (yg_upd),
        .idx     (yg_idx)
    );

    // An accumulator store always goes out as a write on X
    always_comb begin
        x_is_write = x_write || acc_store;
    end

    // X output register: capture on request, otherwise hold address and drop strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_ea      <= '0;
            x_ptr_upd <= '0;
            x_rd      <= 1'b0;
            x_wr      <= 1'b0;
        end else if (x_req) begin
            x_ea      <= xg_ea;
            x_ptr_upd <= xg_upd;
            x_rd      <= !x_is_write;
            x_wr      <= x_is_write;
        end else begin
            x_rd      <= 1'b0;
            x_wr      <= 1'b0;
        end
    end

    // Y output register: capture during multiply-accumulate fetches, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_ea      <= '0;
            y_ptr_upd <= '0;
            y_ptr_idx <= '0;
            y_rd      <= 1'b0;
        end else if (mac_en) begin
            y_ea      <= yg_ea;
            y_ptr_upd <= yg_upd;
            y_ptr_idx <= yg_idx;
            y_rd      <= 1'b1;
        end else begin
            y_rd      <= 1'b0;
        end
    end

    // R12: the two X strobes never coincide
    p_rw_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_rd && x_wr));

    // R12: a request raises exactly one X strobe
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        x_req |=> (x_rd || x_wr));

    // R6: an accumulator store becomes a write
    p_acc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && acc_store) |=> (x_wr && !x_rd));

    // R3: word-sized X accesses land on an even address
    p_word_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && (!x_byte || acc_store)) |=> !x_ea[0]);

    // R11: idle X drops its strobes and holds its address
    p_x_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !x_req |=> (!x_rd && !x_wr && $stable(x_ea) && $stable(x_ptr_upd)));

    // R7: every Y fetch is a whole word
    p_y_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        y_rd |-> !y_ea[0]);

    // R8: Y reports only one of its two dedicated pointers
    p_y_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        y_rd |-> ((y_ptr_idx == RF_IDX_W'(Y_PTR_A)) || (y_ptr_idx == RF_IDX_W'(Y_PTR_B))));

    // R10: idle Y drops its strobe and holds its address and pointer
    p_y_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_en |=> (!y_rd && $stable(y_ea) && $stable(y_ptr_upd)));

    // R4: an in-range post-increment stays inside a buffer longer than one step
    p_mod_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && x_mod_en && (x_mode == 3'd1) && (x_ptr >= x_mod_lo) &&
         (x_ptr <= x_mod_hi) && (x_mod_hi >= x_mod_lo + AW'(2)))
        |=> ((x_ptr_upd >= $past(x_mod_lo)) && (x_ptr_upd <= $past(x_mod_hi))));
endmodule

// File: tb/agu_dual_test.sv
// Self-checking sweep bench for the dual address generator.
module agu_dual_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_req = 1'b0, x_write = 1'b0, acc_store = 1'b0;
    logic [2:0]  x_mode = '0;
    logic        x_byte = 1'b0;
    logic [15:0] x_ptr = '0, x_offset = 16'h0021;
    logic        x_mod_en = 1'b0;
    logic [15:0] x_mod_lo = 16'h0104, x_mod_hi = 16'h0113;
    logic [3:0]  x_brev_n = 4'd4;
    logic        mac_en = 1'b0, y_sel = 1'b0;
    logic [15:0] y_ptr6 = '0, y_ptr7 = '0;
    logic [1:0]  y_op = '0;
    logic        y_mod_en = 1'b0;
    logic [15:0] y_mod_lo = 16'h0804, y_mod_hi = 16'h0813;
    logic [15:0] x_ea, x_ptr_upd, y_ea, y_ptr_upd;
    logic        x_rd, x_wr, y_rd;
    logic [3:0]  y_ptr_idx;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit reported = 0;

    agu_dual uut (
        .clk(clk), .rst_n(rst_n), .x_req(x_req), .x_write(x_write),
        .acc_store(acc_store), .x_mode(x_mode), .x_byte(x_byte),
        .x_ptr(x_ptr), .x_offset(x_offset), .x_mod_en(x_mod_en),
        .x_mod_lo(x_mod_lo), .x_mod_hi(x_mod_hi), .x_brev_n(x_brev_n),
        .mac_en(mac_en), .y_sel(y_sel), .y_ptr6(y_ptr6), .y_ptr7(y_ptr7),
        .y_op(y_op), .y_mod_en(y_mod_en), .y_mod_lo(y_mod_lo),
        .y_mod_hi(y_mod_hi), .x_ea(x_ea), .x_ptr_upd(x_ptr_upd),
        .x_rd(x_rd), .x_wr(x_wr), .y_ea(y_ea), .y_ptr_upd(y_ptr_upd),
        .y_ptr_idx(y_ptr_idx), .y_rd(y_rd)
    );

    always #5 clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=50000", cycles);
            report();
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] wrapv(input logic [15:0] v, input logic en,
                                          input logic [15:0] lo, input logic [15:0] hi);
        if (en && v > hi) return lo + (v - hi - 16'd1);
        if (en && v < lo) return hi - (lo - v - 16'd1);
        return v;
    endfunction

    // Reversed-carry increment, modelled by walking the carry bit by bit
    function automatic logic [15:0] brev_model(input logic [15:0] p, input bit word, input int n);
        logic [15:0] r = p;
        int s = word ? 1 : 0;
        bit done = 0;
        for (int k = s + n - 1; k >= s; k--) begin
            if (!done) begin
                if (r[k]) r[k] = 1'b0;
                else begin r[k] = 1'b1; done = 1; end
            end
        end
        return r;
    endfunction

    // One X access: drive, let one edge pass, compare
    task automatic x_access(input logic [2:0] m, input logic b, input logic acc,
                            input logic wr, input logic [15:0] p, input logic men);
        logic [15:0] e_ea, e_upd, step;
        bit word;
        string tag;
        x_req = 1; x_mode = m; x_byte = b; acc_store = acc; x_write = wr;
        x_ptr = p; x_mod_en = men;
        word = !(b && !acc);
        step = word ? 16'd2 : 16'd1;
        e_ea = p; e_upd = p;
        case (m)
            3'd1: e_upd = wrapv(p + step, men, x_mod_lo, x_mod_hi);
            3'd2: e_upd = wrapv(p - step, men, x_mod_lo, x_mod_hi);
            3'd3: begin e_upd = wrapv(p + step, men, x_mod_lo, x_mod_hi); e_ea = e_upd; end
            3'd4: begin e_upd = wrapv(p - step, men, x_mod_lo, x_mod_hi); e_ea = e_upd; end
            3'd5: e_ea = p + x_offset;
            3'd6: e_upd = brev_model(p, word, int'(x_brev_n));
            default: ;
        endcase
        if (word) e_ea[0] = 1'b0;
        if (m == 3'd6) tag = "R5";
        else if (men && m >= 3'd1 && m <= 3'd4) tag = "R4";
        else tag = "R2";
        @(negedge clk);
        check(tag, "x_ea", x_ea, e_ea);
        check(tag, "x_ptr_upd", x_ptr_upd, e_upd);
        check("R3", "x_ea bit0", {15'd0, x_ea[0]}, {15'd0, e_ea[0]});
        check("R12", "x strobes {rd,wr}", {14'd0, x_rd, x_wr},
              {14'd0, !(wr || acc), (wr || acc)});
    endtask

    // One Y fetch: drive, let one edge pass, compare
    task automatic y_fetch(input logic sel, input logic [1:0] op,
                           input logic [15:0] p, input logic men);
        logic [15:0] e_upd, delta;
        mac_en = 1; y_sel = sel; y_op = op; y_mod_en = men;
        if (sel) y_ptr7 = p; else y_ptr6 = p;
        case (op)
            2'd1: delta = 16'd2;
            2'd2: delta = 16'hFFFE;
            2'd3: delta = 16'd4;
            default: delta = 16'd0;
        endcase
        e_upd = (op == 2'd0) ? p : wrapv(p + delta, men, y_mod_lo, y_mod_hi);
        @(negedge clk);
        check("R7", "y_ea", y_ea, {p[15:1], 1'b0});
        check((men && op != 0) ? "R4" : "R9", "y_ptr_upd", y_ptr_upd, e_upd);
        check("R8", "y_ptr_idx", {12'd0, y_ptr_idx}, sel ? 16'd7 : 16'd6);
        check("R7", "y_rd", {15'd0, y_rd}, 16'd1);
    endtask

    initial begin
        logic [15:0] hold_ea, hold_upd;
        // R1: reset clears everything even with requests pending
        x_req = 1; mac_en = 1; x_ptr = 16'h1235; y_ptr6 = 16'h4443;
        repeat (3) @(negedge clk);
        check("R1", "x_ea", x_ea, 16'h0);
        check("R1", "x_ptr_upd", x_ptr_upd, 16'h0);
        check("R1", "x strobes", {14'd0, x_rd, x_wr}, 16'h0);
        check("R1", "y_ea", y_ea, 16'h0);
        check("R1", "y_ptr_upd", y_ptr_upd, 16'h0);
        check("R1", "y_rd/idx", {11'd0, y_rd, y_ptr_idx}, 16'h0);
        x_req = 0; mac_en = 0;
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R4 R5: every mode, size and pointer around the modulo window
        for (int m = 0; m < 7; m++)
            for (int men = 0; men < 2; men++)
                for (int b = 0; b < 2; b++)
                    for (int p = 16'h0100; p < 16'h0120; p++)
                        x_access(3'(m), 1'(b), 1'b0, 1'b0, 16'(p), 1'(men));

        // R5: walk a bit-reversed sequence through its full period
        x_brev_n = 4'd3;
        x_ptr = 16'h0200;
        for (int i = 0; i < 9; i++) x_access(3'd6, 1'b0, 1'b0, 1'b0, x_ptr_upd | 16'h0200, 1'b0);
        x_brev_n = 4'd4;

        // R6: accumulator store forces a word write even with the byte flag set
        x_access(3'd1, 1'b1, 1'b1, 1'b0, 16'h0201, 1'b0);
        check("R6", "acc store upd", x_ptr_upd, 16'h0203);
        check("R6", "acc store wr", {15'd0, x_wr}, 16'd1);

        // R12 R3: plain byte write keeps odd address
        x_access(3'd0, 1'b1, 1'b0, 1'b1, 16'h0333, 1'b0);
        check("R3", "byte write ea", x_ea, 16'h0333);

        // R11: idle X holds
        hold_ea = x_ea; hold_upd = x_ptr_upd;
        x_req = 0; x_ptr = 16'h7777; x_mode = 3'd1;
        @(negedge clk);
        check("R11", "x strobes idle", {14'd0, x_rd, x_wr}, 16'h0);
        check("R11", "x_ea held", x_ea, hold_ea);
        @(negedge clk);
        check("R11", "x_ptr_upd held", x_ptr_upd, hold_upd);

        // R7 R8 R9 R4: every Y code on both pointers, with and without wrap
        for (int s = 0; s < 2; s++)
            for (int men = 0; men < 2; men++)
                for (int op = 0; op < 4; op++)
                    for (int p = 16'h0800; p < 16'h0818; p++)
                        y_fetch(1'(s), 2'(op), 16'(p), 1'(men));

        // R7: X and Y in the same cycle
        x_req = 1; x_mode = 3'd1; x_byte = 0; x_write = 0; acc_store = 0;
        x_ptr = 16'h0400; x_mod_en = 0;
        y_fetch(1'b1, 2'd1, 16'h0812, 1'b1);
        check("R7", "concurrent x_ea", x_ea, 16'h0400);
        check("R7", "concurrent x_rd", {15'd0, x_rd}, 16'd1);

        // R10: idle Y holds
        hold_ea = y_ea; hold_upd = y_ptr_upd;
        x_req = 0; mac_en = 0; y_ptr7 = 16'h0900; y_ptr6 = 16'h0A00; y_op = 2'd3;
        @(negedge clk);
        check("R10", "y_rd idle", {15'd0, y_rd}, 16'd0);
        check("R10", "y_ea held", y_ea, hold_ea);
        @(negedge clk);
        check("R10", "y_ptr_upd held", y_ptr_upd, hold_upd);

        report();
    end
endmodule